// File: doc/BRIEF.md
# Toggle-on-write interrupt controller for a serial-peripheral datapath

This block gathers the interrupt causes raised by a serial-peripheral transfer datapath (byte transfers, underrun, overrun, FIFO fill levels) into a sticky cause register. The cause register is masked by a per-cause enable register. The masked result is gated by a single master enable to drive one level-sensitive interrupt line. Software reaches the three registers over a simple 32-bit register bus: a select strobe, a write strobe, a byte address, and write and read data. The datapath reports through single-cycle event pulses and two level inputs.

Software acknowledges causes by writing the cause register. Each one bit in the written word inverts the matching flag instead of forcing it to zero. The two receive-side level conditions are sampled on every register access, whatever the address, and they set their flags again for as long as they persist. A cause that arrives in the same cycle as a software toggle of that flag wins, and the flag ends up set.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: After reset the master enable, cause and enable registers all read zero and `irq_o` is low.
- R2: The master enable register sits at byte address 0x1C. Only bit 31 is stored; all other bits read back as zero.
- R3: The cause enable register sits at byte address 0x28. It stores only the cause bits, mask 0x0000017C; all other bits read back as zero.
- R4: A write to the cause register at byte address 0x20 inverts each implemented cause bit (mask 0x0000017C) written as one. Bits outside the mask stay zero.
- R5: A one-cycle `byte_done_i` pulse sets cause bit 2 (transmit empty) and cause bit 8 (receive available).
- R6: One-cycle pulses set these cause bits: `tx_underrun_i` sets bit 3, `rx_fill_i` sets bit 4, `rx_overrun_i` sets bit 5, `tx_half_i` sets bit 6.
- R7: On any bus access cycle (read or write, any address), `rx_avail_lvl_i` high sets bit 8 and `rx_full_lvl_i` high sets bit 4. Without an access, the level inputs have no effect. Read data shows the register value from before that access.
- R8: When a cause set (event or level on access) and a software toggle hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when master enable bit 31 is one and at least one cause bit is set together with its enable bit. It follows register changes in the cycle after the write edge.
- R10: Accesses to other addresses change no register and read zero. Reading the cause register does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | REG_W | Write data |
| bus_rdata_o | output | REG_W | Read data, valid in the access cycle |
| byte_done_i | input | 1 | Pulse: one byte transferred |
| tx_underrun_i | input | 1 | Pulse: transmit underrun |
| tx_half_i | input | 1 | Pulse: transmit FIFO half empty |
| rx_overrun_i | input | 1 | Pulse: receive overrun |
| rx_fill_i | input | 1 | Pulse: receive FIFO became full |
| rx_avail_lvl_i | input | 1 | Level: receive FIFO not empty |
| rx_full_lvl_i | input | 1 | Level: receive FIFO full |
| irq_o | output | 1 | Level interrupt request |

## Verification
Read data is combinational from the registers, so the bench samples it a quarter period after driving the access, before the edge that performs the access. Every register change (writes, event pulses and level sets taken on an access) lands on the next rising edge. `irq_o` is a pure combination of the registers, so it is due one edge after the write that changed them, and the bench samples it at the following falling edge. Level-driven sets show up only in a second read, because the first read returns the value from before its own access; the bench's model follows that rule.

// File: rtl/irq_tog_pkg.sv
package irq_tog_pkg;

  localparam int unsigned B_TX_EMPTY = 2;
  localparam int unsigned B_TX_UNDER = 3;
  localparam int unsigned B_RX_FULL  = 4;
  localparam int unsigned B_RX_OVER  = 5;
  localparam int unsigned B_TX_HALF  = 6;
  localparam int unsigned B_RX_AVAIL = 8;

  localparam logic [31:0] CAUSE_MASK32 =
    (32'd1 << B_TX_EMPTY) | (32'd1 << B_TX_UNDER) | (32'd1 << B_RX_FULL) |
    (32'd1 << B_RX_OVER)  | (32'd1 << B_TX_HALF)  | (32'd1 << B_RX_AVAIL);

  typedef struct packed {
    logic byte_done;
    logic tx_underrun;
    logic tx_half;
    logic rx_overrun;
    logic rx_fill;
  } evt_t;

  typedef struct packed {
    logic access;
    logic rd_gie;
    logic rd_isr;
    logic rd_ier;
    logic wr_gie;
    logic wr_isr;
    logic wr_ier;
  } dec_t;

  function automatic bit is_cause(int unsigned pos);
    return (pos == B_TX_EMPTY) || (pos == B_TX_UNDER) || (pos == B_RX_FULL) ||
           (pos == B_RX_OVER)  || (pos == B_TX_HALF)  || (pos == B_RX_AVAIL);
  endfunction

endpackage

// File: rtl/irq_tog_rst_sync.sv
module irq_tog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/irq_tog_decode.sv
module irq_tog_decode
  import irq_tog_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned OFF_GIE = 'h1C,
  parameter int unsigned OFF_ISR = 'h20,
  parameter int unsigned OFF_IER = 'h28
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_GIE = ADDR_W'(OFF_GIE);
  localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(OFF_ISR);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(OFF_IER);

  logic [ADDR_W-1:0] word_addr;
  logic hit_gie, hit_isr, hit_ier;

  always_comb begin
    word_addr = addr_i & WORD_MASK;
    hit_gie   = (word_addr == A_GIE);
    hit_isr   = (word_addr == A_ISR);
    hit_ier   = (word_addr == A_IER);

    dec_o.access = sel_i;
    dec_o.rd_gie = sel_i & ~wr_i & hit_gie;
    dec_o.rd_isr = sel_i & ~wr_i & hit_isr;
    dec_o.rd_ier = sel_i & ~wr_i & hit_ier;
    dec_o.wr_gie = sel_i &  wr_i & hit_gie;
    dec_o.wr_isr = sel_i &  wr_i & hit_isr;
    dec_o.wr_ier = sel_i &  wr_i & hit_ier;
  end

endmodule

// File: rtl/irq_tog_cell.sv
module irq_tog_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic tgl_i,
  output logic q_o
);

  logic q_d;
  logic q_q;
  logic q_en;

  always_comb begin
    q_en = set_i | tgl_i;
    if (set_i) q_d = 1'b1;
    else       q_d = ~q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/irq_tog_status.sv
module irq_tog_status
  import irq_tog_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evt_t             evt_i,
  input  logic             access_i,
  input  logic             lvl_avail_i,
  input  logic             lvl_full_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] stat_o
);

  logic [REG_W-1:0] set_v;
  logic [REG_W-1:0] tgl_v;
  logic             unused_tgl_bits;

  always_comb begin
    set_v = '0;
    if (evt_i.byte_done) begin
      set_v[B_TX_EMPTY] = 1'b1;
      set_v[B_RX_AVAIL] = 1'b1;
    end
    if (evt_i.tx_underrun)       set_v[B_TX_UNDER] = 1'b1;
    if (evt_i.rx_fill)           set_v[B_RX_FULL]  = 1'b1;
    if (evt_i.rx_overrun)        set_v[B_RX_OVER]  = 1'b1;
    if (evt_i.tx_half)           set_v[B_TX_HALF]  = 1'b1;
    if (access_i && lvl_avail_i) set_v[B_RX_AVAIL] = 1'b1;
    if (access_i && lvl_full_i)  set_v[B_RX_FULL]  = 1'b1;
    tgl_v = wr_i ? wdata_i : '0;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (is_cause(i)) begin : g_cell
      irq_tog_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v[i]),
        .tgl_i (tgl_v[i]),
        .q_o   (stat_o[i])
      );
    end else begin : g_zero
      assign stat_o[i] = 1'b0;
    end
  end

  assign unused_tgl_bits = ^{tgl_v, set_v};

endmodule

// File: rtl/irq_tog_enables.sv
module irq_tog_enables
  import irq_tog_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_gie_i,
  input  logic             wr_ier_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             gie_o,
  output logic [REG_W-1:0] ier_o
);

  localparam int unsigned GIE_BIT = REG_W - 1;

  logic gie_q;
  logic gie_d;
  logic unused_wdata;

  assign gie_d = wdata_i[GIE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gie_q <= 1'b0;
    else if (wr_gie_i) gie_q <= gie_d;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_ier
    if (is_cause(i)) begin : g_reg
      logic en_q;
      logic en_d;
      assign en_d = wdata_i[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        en_q <= 1'b0;
        else if (wr_ier_i) en_q <= en_d;
      end
      assign ier_o[i] = en_q;
    end else begin : g_zero
      assign ier_o[i] = 1'b0;
    end
  end

  assign gie_o        = gie_q;
  assign unused_wdata = ^wdata_i;

endmodule

// File: rtl/irq_tog_combine.sv
module irq_tog_combine #(
  parameter int unsigned REG_W = 32
) (
  input  logic [REG_W-1:0] stat_i,
  input  logic [REG_W-1:0] ier_i,
  input  logic             gie_i,
  output logic             irq_o
);

  logic [REG_W-1:0] pend_v;
  logic             any_pend;

  always_comb begin
    pend_v   = stat_i & ier_i;
    any_pend = |pend_v;
    irq_o    = gie_i & any_pend;
  end

endmodule

// File: rtl/irq_toggle_ctrl.sv
module irq_toggle_ctrl
  import irq_tog_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned OFF_GIE = 'h1C,
  parameter int unsigned OFF_ISR = 'h20,
  parameter int unsigned OFF_IER = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              byte_done_i,
  input  logic              tx_underrun_i,
  input  logic              tx_half_i,
  input  logic              rx_overrun_i,
  input  logic              rx_fill_i,
  input  logic              rx_avail_lvl_i,
  input  logic              rx_full_lvl_i,
  output logic              irq_o
);

  localparam int unsigned GIE_BIT = REG_W - 1;

  logic             rst_sync_n;
  dec_t             dec;
  evt_t             evt;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] ier_q;
  logic             gie_q;
  logic [REG_W-1:0] gie_word;

  irq_tog_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_tog_decode #(
    .ADDR_W  (ADDR_W),
    .OFF_GIE (OFF_GIE),
    .OFF_ISR (OFF_ISR),
    .OFF_IER (OFF_IER)
  ) u_dec (
    .sel_i  (bus_sel_i),
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .dec_o  (dec)
  );

  always_comb begin
    evt.byte_done   = byte_done_i;
    evt.tx_underrun = tx_underrun_i;
    evt.tx_half     = tx_half_i;
    evt.rx_overrun  = rx_overrun_i;
    evt.rx_fill     = rx_fill_i;
  end

  irq_tog_status #(.REG_W(REG_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .evt_i       (evt),
    .access_i    (dec.access),
    .lvl_avail_i (rx_avail_lvl_i),
    .lvl_full_i  (rx_full_lvl_i),
    .wr_i        (dec.wr_isr),
    .wdata_i     (bus_wdata_i),
    .stat_o      (stat_q)
  );

  irq_tog_enables #(.REG_W(REG_W)) u_en (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_gie_i (dec.wr_gie),
    .wr_ier_i (dec.wr_ier),
    .wdata_i  (bus_wdata_i),
    .gie_o    (gie_q),
    .ier_o    (ier_q)
  );

  irq_tog_combine #(.REG_W(REG_W)) u_comb (
    .stat_i (stat_q),
    .ier_i  (ier_q),
    .gie_i  (gie_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    gie_word          = '0;
    gie_word[GIE_BIT] = gie_q;
    unique case (1'b1)
      dec.rd_gie: bus_rdata_o = gie_word;
      dec.rd_isr: bus_rdata_o = stat_q;
      dec.rd_ier: bus_rdata_o = ier_q;
      default:    bus_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_tog_checker.sv
module irq_tog_checker
  import irq_tog_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned OFF_ISR = 'h20,
  parameter int unsigned OFF_IER = 'h28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              byte_done_i,
  input logic              tx_underrun_i,
  input logic              tx_half_i,
  input logic              rx_overrun_i,
  input logic              rx_fill_i,
  input logic              rx_avail_lvl_i,
  input logic              rx_full_lvl_i,
  input logic [31:0]       stat_q,
  input logic [31:0]       ier_q,
  input logic              gie_q,
  input logic              irq_o
);

  logic wr_isr, wr_ier, any_set;

  assign wr_isr  = bus_sel_i && bus_wr_i && ((bus_addr_i & ~ADDR_W'(3)) == ADDR_W'(OFF_ISR));
  assign wr_ier  = bus_sel_i && bus_wr_i && ((bus_addr_i & ~ADDR_W'(3)) == ADDR_W'(OFF_IER));
  assign any_set = byte_done_i || tx_underrun_i || tx_half_i || rx_overrun_i || rx_fill_i ||
                   (bus_sel_i && (rx_avail_lvl_i || rx_full_lvl_i));

  // R1: held in reset, nothing pending and output low
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!irq_o && stat_q == 32'd0 && ier_q == 32'd0 && !gie_q);
    end
  end

  p_ier_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ier |=> $stable(ier_q));

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_isr && !any_set) |=> stat_q == $past(stat_q ^ (bus_wdata_i & CAUSE_MASK32)));

  p_byte_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_i |=> (stat_q[B_TX_EMPTY] && stat_q[B_RX_AVAIL]));

  p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun_i |=> stat_q[B_TX_UNDER]);

  p_level_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && rx_avail_lvl_i) |=> stat_q[B_RX_AVAIL]);

  p_set_beats_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_isr && rx_overrun_i && bus_wdata_i[B_RX_OVER]) |=> stat_q[B_RX_OVER]);

  p_gie_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_o);

endmodule

bind irq_toggle_ctrl irq_tog_checker #(
  .ADDR_W  (ADDR_W),
  .OFF_ISR (OFF_ISR),
  .OFF_IER (OFF_IER)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .bus_sel_i      (bus_sel_i),
  .bus_wr_i       (bus_wr_i),
  .bus_addr_i     (bus_addr_i),
  .bus_wdata_i    (bus_wdata_i[31:0]),
  .byte_done_i    (byte_done_i),
  .tx_underrun_i  (tx_underrun_i),
  .tx_half_i      (tx_half_i),
  .rx_overrun_i   (rx_overrun_i),
  .rx_fill_i      (rx_fill_i),
  .rx_avail_lvl_i (rx_avail_lvl_i),
  .rx_full_lvl_i  (rx_full_lvl_i),
  .stat_q         (stat_q[31:0]),
  .ier_q          (ier_q[31:0]),
  .gie_q          (gie_q),
  .irq_o          (irq_o)
);

// File: tb/test_irq_toggle_ctrl.sv
module test_irq_toggle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  A_GIE = 8'h1C;
  localparam logic [7:0]  A_ISR = 8'h20;
  localparam logic [7:0]  A_IER = 8'h28;
  localparam logic [31:0] MASK  = 32'h0000017C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [4:0]  ev;
  logic        lvl_avail, lvl_full;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_stat, m_ier;
  logic        m_gie;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_toggle_ctrl i_irq_toggle_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel_i      (sel),
    .bus_wr_i       (wr),
    .bus_addr_i     (addr),
    .bus_wdata_i    (wdata),
    .bus_rdata_o    (rdata),
    .byte_done_i    (ev[4]),
    .tx_underrun_i  (ev[3]),
    .tx_half_i      (ev[2]),
    .rx_overrun_i   (ev[1]),
    .rx_fill_i      (ev[0]),
    .rx_avail_lvl_i (lvl_avail),
    .rx_full_lvl_i  (lvl_full),
    .irq_o          (irq)
  );

  function automatic logic [31:0] ev_bits(logic [4:0] e);
    logic [31:0] s = '0;
    if (e[4]) s |= 32'h104;
    if (e[3]) s |= 32'h008;
    if (e[2]) s |= 32'h040;
    if (e[1]) s |= 32'h020;
    if (e[0]) s |= 32'h010;
    return s;
  endfunction

  function automatic logic [31:0] lvl_bits();
    return (lvl_avail ? 32'h100 : 32'h0) | (lvl_full ? 32'h010 : 32'h0);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start at a falling edge and end at a falling edge
  task automatic bus_wr(logic [7:0] a, logic [31:0] d, logic [4:0] e = 5'd0);
    logic [31:0] s;
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d; ev = e;
    s = ev_bits(e) | lvl_bits();
    if (a == A_ISR)      m_stat = (m_stat ^ (d & MASK)) | s;
    else                 m_stat = m_stat | s;
    if (a == A_IER) m_ier = d & MASK;
    if (a == A_GIE) m_gie = d[31];
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; ev = 5'd0;
  endtask

  task automatic bus_rd(string tag, logic [7:0] a, logic [31:0] exp);
    sel = 1'b1; wr = 1'b0; addr = a;
    #(CLK_PERIOD/4);
    chk(tag, rdata, exp);
    m_stat = m_stat | lvl_bits();
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic pulse(logic [4:0] e);
    ev = e;
    m_stat = m_stat | ev_bits(e);
    @(negedge clk);
    ev = 5'd0;
  endtask

  task automatic chk_irq(string tag);
    #(CLK_PERIOD/4);
    chk(tag, {31'd0, irq}, {31'd0, m_gie & |(m_stat & m_ier)});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int causes[6] = '{2, 3, 4, 5, 6, 8};
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; ev = '0;
    lvl_avail = 1'b0; lvl_full = 1'b0;
    m_stat = '0; m_ier = '0; m_gie = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd("R1 gie", A_GIE, 32'h0);
    bus_rd("R1 isr", A_ISR, 32'h0);
    bus_rd("R1 ier", A_IER, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 master enable keeps bit 31 only
    bus_wr(A_GIE, 32'hFFFF_FFFF);
    bus_rd("R2 all ones", A_GIE, 32'h8000_0000);
    bus_wr(A_GIE, 32'h7FFF_FFFF);
    bus_rd("R2 low bits", A_GIE, 32'h0);

    // R3 enable register keeps cause bits only
    bus_wr(A_IER, 32'hFFFF_FFFF);
    bus_rd("R3 all ones", A_IER, MASK);
    bus_wr(A_IER, 32'h0000_0000);
    bus_rd("R3 zero", A_IER, 32'h0);

    // R4 exhaustive toggle sweep over the low nine bits, plus upper bits
    for (int v = 0; v < 512; v++) begin
      bus_wr(A_ISR, 32'(v));
      bus_rd("R4 toggle sweep", A_ISR, m_stat);
    end
    bus_wr(A_ISR, 32'hFFFF_FE00 | m_stat);
    bus_rd("R4 upper ignored", A_ISR, 32'h0);

    // R5 byte transfer
    pulse(5'b10000);
    bus_rd("R5 byte done", A_ISR, 32'h104);
    bus_wr(A_ISR, m_stat);

    // R6 each event pulse alone
    for (int k = 0; k < 4; k++) begin
      pulse(5'b00001 << k);
      bus_rd("R6 event", A_ISR, ev_bits(5'b00001 << k));
      bus_wr(A_ISR, m_stat);
    end

    // R7 level inputs only act on access
    lvl_avail = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd("R7 first read pre-access", A_ISR, 32'h0);
    bus_rd("R7 second read", A_ISR, 32'h100);
    lvl_avail = 1'b0;
    bus_wr(A_ISR, 32'h100);
    lvl_full = 1'b1;
    bus_wr(8'h2C, 32'h0);
    lvl_full = 1'b0;
    bus_rd("R7 full via other addr", A_ISR, 32'h010);
    bus_wr(A_ISR, 32'h010);
    bus_rd("R7 cleared", A_ISR, 32'h0);

    // R8 set beats toggle
    lvl_avail = 1'b1;
    bus_rd("R8 prime", A_ISR, 32'h0);
    bus_wr(A_ISR, 32'h100);
    lvl_avail = 1'b0;
    bus_rd("R8 level vs toggle", A_ISR, 32'h100);
    bus_wr(A_ISR, 32'h100);
    bus_wr(A_ISR, 32'h008);
    bus_wr(A_ISR, 32'h008, 5'b01000);
    bus_rd("R8 event vs toggle", A_ISR, 32'h008);
    bus_wr(A_ISR, 32'h020, 5'b00010);
    bus_rd("R8 event vs toggle clear", A_ISR, 32'h028);
    bus_wr(A_ISR, m_stat);

    // R9 sweep every cause x enable x master enable
    foreach (causes[i]) begin
      for (int en = 0; en < 2; en++) begin
        for (int g = 0; g < 2; g++) begin
          bus_wr(A_ISR, m_stat ^ (32'd1 << causes[i]));
          bus_wr(A_IER, en != 0 ? (32'd1 << causes[i]) : (MASK & ~(32'd1 << causes[i])));
          bus_wr(A_GIE, g != 0 ? 32'h8000_0000 : 32'h0);
          chk_irq("R9 combine");
          @(negedge clk);
        end
      end
    end
    // R9 output drops the cycle after the acknowledge
    bus_wr(A_IER, MASK);
    bus_wr(A_GIE, 32'h8000_0000);
    chk_irq("R9 asserted");
    bus_wr(A_ISR, m_stat);
    chk_irq("R9 deasserted");

    // R10 other addresses and non-clearing reads
    pulse(5'b00100);
    bus_wr(8'h24, 32'hFFFF_FFFF);
    bus_rd("R10 other addr read", 8'h24, 32'h0);
    bus_rd("R10 isr kept", A_ISR, 32'h040);
    bus_rd("R10 isr read again", A_ISR, 32'h040);
    bus_rd("R10 ier kept", A_IER, MASK);
    bus_rd("R10 gie kept", A_GIE, 32'h8000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule